// File: doc/BRIEF.md
# Scrolling Starfield Pixel Generator

The block answers one question per pixel: is a background star lit at the raster position the timing generator is presenting right now? It does not store a list of star positions. It holds a single vertical base line. Every star's position is worked out from that base line and a fixed horizontal origin, using constant offsets. Because of this, the whole field drifts as one when the base moves.

The field has 28 stars, 2x2 pixels each, in an 800x480 visible area. The stars form four interleaved phases of seven stars. Along the x axis, consecutive stars are 22 pixels apart, so stars of the same phase end up 88 pixels apart.

The visible height is cut into seven bands of 68 lines. Within a phase, each star takes a different band. The band choice is rotated from phase to phase, so two stars that are horizontally adjacent never share a band.

A frame-start pulse with scrolling enabled moves the field down one line, wrapping at the bottom. Each star gets one of four colours according to its phase.

Top module: `starfield_gen`

## Requirements
- R1: While `rstN` is low, `starHit` is 0, `starColour` is 0 and the base line is 0.
- R2: Star k (0..27) has phase p = k mod 4 and index i = k div 4. Its left column is BASE_X + 22*k, with BASE_X defaulting to 100. It covers that column and the next one.
- R3: Star k's top line is (baseLine + 68*((i + 2*p) mod 7)) mod 480. It covers that line and the next one modulo 480, so a star whose top line is 479 also lights line 0.
- R4: `starHit` is 1 only for a pixel presented with `displayEn` high. With `displayEn` low, both outputs are 0.
- R5: The outputs describe the pixel inputs of the previous clock cycle. There is exactly one register stage.
- R6: A cycle with `frameStart` and `scrollEn` both high increments the base line by one. The pixel presented in that same cycle is judged against the old base line.
- R7: A cycle with `frameStart` high and `scrollEn` low leaves the base line unchanged.
- R8: The base line wraps from 479 back to 0.
- R9: A lit star's colour is set by its phase (12-bit RGB): phase 0 = 0xFFF, phase 1 = 0xF44, phase 2 = 0x4F4, phase 3 = 0x48F. When no star is hit, `starColour` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixX | input | 10 | Current pixel column |
| pixY | input | 9 | Current pixel line |
| displayEn | input | 1 | High while the pixel is in the visible area |
| frameStart | input | 1 | One-cycle pulse at the start of a frame |
| scrollEn | input | 1 | Allows a frame-start pulse to move the field |
| starHit | output | 1 | A star is lit at the previous cycle's pixel |
| starColour | output | 12 | RGB colour of that star, 0 when none |

## Verification
Two functions can land on the same clock edge: a scroll step and the judgement of a pixel. When a frame-start pulse with scrolling enabled coincides with a visible pixel, that pixel must still be judged against the old base line. The new line applies only from the next pixel onward.

The bench provokes this collision repeatedly. In one run it pulses frame-start on every cycle while aiming each pixel at a star edge that the step is about to move. A per-cycle reference model, which updates its own base line only after computing the expectation, judges the outcome. That same run carries the base line through the 479-to-0 wrap, where a star straddles the bottom and top lines.

// File: rtl/starfield_pkg.sv
package starfield_pkg;

  typedef struct packed {
    logic advance;
    logic wrap;
  } sfCtrl_t;

  function automatic logic [11:0] phaseColour(input int phase);
    case (phase % 4)
      0:       return 12'hFFF;
      1:       return 12'hF44;
      2:       return 12'h4F4;
      default: return 12'h48F;
    endcase
  endfunction

endpackage

// File: rtl/starfield_ctrl.sv
module starfield_ctrl
  import starfield_pkg::*;
#(
  parameter int V_VIS = 480,
  localparam int Y_W = $clog2(V_VIS)
) (
  input  logic           frameStart,
  input  logic           scrollEn,
  input  logic [Y_W-1:0] baseY,
  output sfCtrl_t        strobes
);

  always_comb begin
    strobes.advance = frameStart && scrollEn;
    strobes.wrap    = (baseY == Y_W'(V_VIS - 1));
  end

endmodule

// File: rtl/starfield_datapath.sv
module starfield_datapath
  import starfield_pkg::*;
#(
  parameter int H_VIS     = 800,
  parameter int V_VIS     = 480,
  parameter int PHASES    = 4,
  parameter int PER_PHASE = 7,
  parameter int H_STEP    = 22,
  parameter int BASE_X    = 100,
  parameter int BAND_ROT  = 2,
  parameter int STAR_W    = 2,
  parameter int STAR_H    = 2,
  localparam int X_W    = $clog2(H_VIS),
  localparam int Y_W    = $clog2(V_VIS),
  localparam int NSTARS = PHASES * PER_PHASE,
  localparam int BAND_H = V_VIS / PER_PHASE
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [X_W-1:0] pixX,
  input  logic [Y_W-1:0] pixY,
  input  logic           displayEn,
  input  sfCtrl_t        strobes,
  output logic [Y_W-1:0] baseY,
  output logic           starHit,
  output logic [11:0]    starColour
);

  logic [NSTARS-1:0] hitVec;
  logic              anyHit;
  logic [11:0]       hitColour;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseY <= '0;
    else if (strobes.advance) baseY <= strobes.wrap ? '0 : baseY + 1'b1;
  end

  for (genvar k = 0; k < NSTARS; k++) begin : g_star
    localparam int PH   = k % PHASES;
    localparam int IDX  = k / PHASES;
    localparam int SX   = BASE_X + H_STEP * k;
    localparam int BIAS = BAND_H * ((IDX + BAND_ROT * PH) % PER_PHASE);
    logic [Y_W:0] ySum, yTop, yDist;
    logic         xIn;
    always_comb begin
      ySum  = {1'b0, baseY} + (Y_W+1)'(BIAS);
      yTop  = (ySum >= (Y_W+1)'(V_VIS)) ? ySum - (Y_W+1)'(V_VIS) : ySum;
      yDist = ({1'b0, pixY} >= yTop) ? {1'b0, pixY} - yTop
                                     : {1'b0, pixY} + (Y_W+1)'(V_VIS) - yTop;
      xIn   = (pixX >= X_W'(SX)) && ((pixX - X_W'(SX)) < X_W'(STAR_W));
      hitVec[k] = xIn && (yDist < (Y_W+1)'(STAR_H));
    end
  end

  always_comb begin
    anyHit    = |hitVec;
    hitColour = '0;
    for (int k = NSTARS - 1; k >= 0; k--)
      if (hitVec[k]) hitColour = phaseColour(k % PHASES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      starHit    <= 1'b0;
      starColour <= '0;
    end else begin
      starHit    <= displayEn && anyHit;
      starColour <= (displayEn && anyHit) ? hitColour : '0;
    end
  end

  // R8
  baseline_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseY < Y_W'(V_VIS));

  // R6
  baseline_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && baseY != Y_W'(V_VIS - 1)) |=> baseY == $past(baseY) + 1'b1);

  // R8
  baseline_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && baseY == Y_W'(V_VIS - 1)) |=> baseY == '0);

  // R7
  baseline_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(baseY));

  // R4
  blank_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !displayEn |=> (!starHit && starColour == '0));

  // R9
  dark_colour_chk: assert property (@(posedge clk) disable iff (!rstN)
    !starHit |-> starColour == '0);

endmodule

// File: rtl/starfield_gen.sv
module starfield_gen
  import starfield_pkg::*;
#(
  parameter int H_VIS  = 800,
  parameter int V_VIS  = 480,
  parameter int BASE_X = 100,
  localparam int X_W = $clog2(H_VIS),
  localparam int Y_W = $clog2(V_VIS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [X_W-1:0] pixX,
  input  logic [Y_W-1:0] pixY,
  input  logic           displayEn,
  input  logic           frameStart,
  input  logic           scrollEn,
  output logic           starHit,
  output logic [11:0]    starColour
);

  sfCtrl_t        strobes;
  logic [Y_W-1:0] baseY;

  starfield_ctrl #(.V_VIS(V_VIS)) u_ctrl (
    .frameStart (frameStart),
    .scrollEn   (scrollEn),
    .baseY      (baseY),
    .strobes    (strobes)
  );

  starfield_datapath #(
    .H_VIS  (H_VIS),
    .V_VIS  (V_VIS),
    .BASE_X (BASE_X)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pixX       (pixX),
    .pixY       (pixY),
    .displayEn  (displayEn),
    .strobes    (strobes),
    .baseY      (baseY),
    .starHit    (starHit),
    .starColour (starColour)
  );

endmodule

// File: tb/sim_starfield_gen.sv
module sim_starfield_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] pixX = '0;
  logic [8:0] pixY = '0;
  logic       displayEn = 1'b0;
  logic       frameStart = 1'b0;
  logic       scrollEn = 1'b0;
  logic       starHit;
  logic [11:0] starColour;

  int errors = 0;
  int checks = 0;
  int modelBase = 0;
  bit expHit = 0;
  int expCol = 0;
  string expTag = "R5";
  bit pending = 0;
  bit done = 0;

  starfield_gen u0 (
    .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY),
    .displayEn(displayEn), .frameStart(frameStart), .scrollEn(scrollEn),
    .starHit(starHit), .starColour(starColour)
  );

  always #2 clk = ~clk;

  function automatic int colourOf(int p);
    int c[4] = '{'hFFF, 'hF44, 'h4F4, 'h48F};
    return c[p];
  endfunction

  function automatic int starX(int k);
    return 100 + 22 * k;
  endfunction

  function automatic int starY(int k, int base);
    return (base + 68 * (((k / 4) + 2 * (k % 4)) % 7)) % 480;
  endfunction

  // returns colour, or -1 when no star covers (x,y)
  function automatic int refLookup(int x, int y, int base);
    for (int k = 0; k < 28; k++) begin
      int dx = x - starX(k);
      int dy = (y - starY(k, base) + 480) % 480;
      if (dx >= 0 && dx < 2 && dy < 2) return colourOf(k % 4);
    end
    return -1;
  endfunction

  task automatic check(string tag, bit gotHit, int gotCol, bit wantHit, int wantCol);
    checks++;
    if (gotHit !== wantHit || gotCol != wantCol) begin
      errors++;
      $display("FAIL %s: hit=%0b colour=%03h expected hit=%0b colour=%03h",
               tag, gotHit, gotCol, wantHit, wantCol);
    end
  endtask

  // drive one pixel at negedge after checking the previous one
  task automatic step(int x, int y, bit de, bit fs, bit sc, string tagOverride);
    int c;
    @(negedge clk);
    if (pending) check(expTag, starHit, int'(starColour), expHit, expCol);
    pixX = 10'(x); pixY = 9'(y); displayEn = de; frameStart = fs; scrollEn = sc;
    c = refLookup(x, y, modelBase);
    expHit = de && (c >= 0);
    expCol = expHit ? c : 0;
    if (tagOverride != "") expTag = tagOverride;
    else if (!de) expTag = "R4";
    else if (fs && sc) expTag = "R6";
    else if (fs) expTag = "R7";
    else if (expHit) expTag = "R2 R3 R9";
    else expTag = "R5";
    pending = 1;
    if (fs && sc) modelBase = (modelBase + 1) % 480;
  endtask

  task automatic aimedStep(bit de, bit fs, bit sc, string tagOverride);
    int k = $urandom % 28;
    int x = starX(k) + int'($urandom % 4) - 1;
    int y = (starY(k, modelBase) + int'($urandom % 4) - 1 + 480) % 480;
    if ($urandom % 5 == 0) begin
      x = $urandom % 800;
      y = $urandom % 480;
    end
    step(x, y, de, fs, sc, tagOverride);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    pixX = 10'(starX(0)); pixY = 9'(starY(0, 0)); displayEn = 1'b1;
    @(negedge clk);
    check("R1", starHit, int'(starColour), 1'b0, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: base line starts at 0 -> star 0 at its reset position
    step(starX(0), starY(0, 0), 1, 0, 0, "R1 R2 R3");
    step(starX(0) + 1, starY(0, 0) + 1, 1, 0, 0, "R2 R3");
    step(starX(0) + 2, starY(0, 0), 1, 0, 0, "R2");
    step(starX(5), starY(5, 0), 0, 0, 0, "R4");
    step(starX(6), starY(6, 0), 1, 0, 0, "R9");
    // mixed traffic
    for (int n = 0; n < 800; n++) begin
      bit fs = ($urandom % 15 == 0);
      aimedStep($urandom % 6 != 0, fs, $urandom % 2, "");
    end
    // frame-start without scroll must not move the field
    for (int n = 0; n < 40; n++) aimedStep(1, 1, 0, "R7");
    // scroll every cycle through the wrap, collisions each cycle
    while (modelBase != 477) aimedStep(1, 1, 1, "");
    for (int n = 0; n < 6; n++) aimedStep(1, 1, 1, "R8 R6");
    // star 0 straddling bottom/top when base line is 479
    while (modelBase != 479) step(0, 0, 1, 1, 1, "R8");
    step(starX(0), 479, 1, 0, 0, "R8 R3");
    step(starX(0), 0, 1, 0, 0, "R8 R3");
    step(starX(0) + 1, 1, 1, 0, 0, "R8 R3");
    step(starX(0), 0, 1, 1, 1, "R8 R6");
    step(starX(0), 0, 1, 0, 0, "R8 R3");
    step(starX(0), 1, 1, 0, 0, "R8 R3");
    for (int n = 0; n < 300; n++) aimedStep($urandom % 4 != 0, $urandom % 10 == 0, 1, "");
    step(0, 0, 0, 0, 0, "R4");
    @(negedge clk);
    check(expTag, starHit, int'(starColour), expHit, expCol);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule